// File: doc/BRIEF.md
# Legacy PCI Interrupt Router

The router takes eight active-low PCI interrupt request lines and turns them into level-sensitive, active-high inputs for an interrupt controller. It presents them as one 24-bit vector of IRQ levels. One input selects the routing scheme.

In programmable (PIC) mode, each request line has its own byte-wide route register. The register names a target IRQ and holds a disable bit. Several lines may name the same IRQ, and that IRQ then carries the OR of their levels. Only a fixed legal set of IRQ numbers is accepted. A write that names an IRQ outside that set leaves the line unrouted and raises a sticky error flag.

In fixed (APIC) mode, the route registers are ignored and line k drives IRQ 16+k. The route registers are reached through a small synchronous byte interface. Address bit 2 selects the group (lines A–D or lines E–H), and address bits 1:0 select the line within the group.

Top module: `pirq_router`

## Requirements
- R1: After reset, irq_out is all zero, route_err is 0, and every route register reads 0x80 (disabled, IRQ field 0).
- R2: In PIC mode, a line whose register has bit 7 = 0 and a legal IRQ number n in bits 3:0 drives irq_out[n] high while its pirq_n input is low. The legal set of n is {3,4,5,6,7,9,10,11,12,14,15}. The output appears one clock after the input or register change. IRQ 0, 1, 2, 8 and 13 are never driven.
- R3: In PIC mode, irq_out[n] is the OR of every enabled line routed to n.
- R4: A line whose register has bit 7 = 1 drives no output in PIC mode.
- R5: A write with bit 7 = 0 and an IRQ number outside the legal set is stored with bit 7 forced to 1. The line therefore stays unrouted, and route_err is set on the next clock.
- R6: route_err stays at 1 until reset, whatever is written later.
- R7: In APIC mode, irq_out[16+k] equals the inverse of pirq_n[k], one clock late, for k = 0..7. The route registers have no effect in this mode.
- R8: In PIC mode irq_out[23:16] is 0. In APIC mode irq_out[15:0] is 0.
- R9: A write with reg_we = 1 stores all 8 bits of reg_wdata into the register at reg_addr, with the bit 7 rule of R5. Address bit 2 selects lines E–H, and bits 1:0 select the line within the group. reg_rdata shows the register at reg_addr one clock after the address is presented.
- R10: A change of apic_mode is reflected in the whole of irq_out at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| apic_mode | input | 1 | 1 selects fixed routing, 0 selects programmable routing |
| pirq_n | input | 8 | Active-low request lines, bit 0 = line A |
| reg_we | input | 1 | Route register write strobe |
| reg_addr | input | 3 | Route register index |
| reg_wdata | input | 8 | Route register write data |
| reg_rdata | output | 8 | Registered read of the addressed route register |
| irq_out | output | 24 | Active-high IRQ levels |
| route_err | output | 1 | Sticky flag for an illegal route write |

## Verification
Every result lands one clock after its cause, because irq_out, reg_rdata and route_err are each a single register stage. The one exception is a register write: it commits at one edge and first affects irq_out at the following edge.

The bench drives inputs on falling edges. After a write it waits until the write has committed, then changes pirq_n and samples on the next falling edge. That sample therefore sees exactly one rising edge past the stimulus.

Expected vectors come from a bench-side model of the route registers and an arithmetic legality test. These are compared over full sweeps of line and IRQ number and over all 256 input patterns in each mode.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  // IRQ numbers a line may be steered to in programmable mode
  localparam logic [15:0] PIC_LEGAL = 16'hDEF8;

  function automatic logic irq_is_legal(input logic [3:0] n);
    return PIC_LEGAL[n];
  endfunction
endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs #(
  parameter int N_LINES = 8,
  parameter int IRQW    = 4,
  parameter int REGW    = 8,
  parameter int AW      = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [AW-1:0]            addr,
  input  logic [REGW-1:0]          wdata,
  output logic [REGW-1:0]          rdata,
  output logic [N_LINES-1:0]       line_en,
  output logic [N_LINES*IRQW-1:0]  line_irq,
  output logic                     err
);
  import pirq_pkg::*;

  localparam logic [REGW-1:0] RST_VAL = REGW'(1) << (REGW-1);

  logic [REGW-1:0] route_q [N_LINES];
  logic [REGW-1:0] wr_val;
  logic            wr_bad;

  always_comb begin
    wr_bad = !wdata[REGW-1] && !irq_is_legal(wdata[IRQW-1:0]);
    wr_val = wdata;
    if (wr_bad) wr_val[REGW-1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_LINES; i++) route_q[i] <= RST_VAL;
      err   <= 1'b0;
      rdata <= '0;
    end else begin
      if (we) begin
        route_q[addr] <= wr_val;
        if (wr_bad) err <= 1'b1;
      end
      rdata <= route_q[addr];
    end
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_dec
    assign line_en[g]                 = !route_q[g][REGW-1];
    assign line_irq[g*IRQW +: IRQW]   = route_q[g][IRQW-1:0];
  end
endmodule

// File: rtl/pirq_pic_map.sv
module pirq_pic_map #(
  parameter int N_LINES = 8,
  parameter int IRQW    = 4,
  parameter int N_IRQ   = 24
) (
  input  logic [N_LINES-1:0]       req,
  input  logic [N_LINES-1:0]       line_en,
  input  logic [N_LINES*IRQW-1:0]  line_irq,
  output logic [N_IRQ-1:0]         irq_vec
);
  localparam int N_PIC = 1 << IRQW;

  for (genvar j = 0; j < N_IRQ; j++) begin : g_irq
    if (j < N_PIC) begin : g_prog
      logic [N_LINES-1:0] hit;
      for (genvar i = 0; i < N_LINES; i++) begin : g_line
        assign hit[i] = req[i] && line_en[i] &&
                        (line_irq[i*IRQW +: IRQW] == IRQW'(j));
      end
      assign irq_vec[j] = |hit;
    end else begin : g_none
      assign irq_vec[j] = 1'b0;
    end
  end
endmodule

// File: rtl/pirq_apic_map.sv
module pirq_apic_map #(
  parameter int N_LINES   = 8,
  parameter int N_IRQ     = 24,
  parameter int APIC_BASE = 16
) (
  input  logic [N_LINES-1:0] req,
  output logic [N_IRQ-1:0]   irq_vec
);
  for (genvar j = 0; j < N_IRQ; j++) begin : g_irq
    if (j >= APIC_BASE && j < APIC_BASE + N_LINES) begin : g_wire
      assign irq_vec[j] = req[j-APIC_BASE];
    end else begin : g_zero
      assign irq_vec[j] = 1'b0;
    end
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router #(
  parameter int N_LINES   = 8,
  parameter int N_IRQ     = 24,
  parameter int IRQW      = 4,
  parameter int APIC_BASE = 16,
  parameter int REGW      = 8,
  parameter int AW        = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               apic_mode,
  input  logic [N_LINES-1:0] pirq_n,
  input  logic               reg_we,
  input  logic [AW-1:0]      reg_addr,
  input  logic [REGW-1:0]    reg_wdata,
  output logic [REGW-1:0]    reg_rdata,
  output logic [N_IRQ-1:0]   irq_out,
  output logic               route_err
);
  logic [N_LINES-1:0]      req;
  logic [N_LINES-1:0]      line_en;
  logic [N_LINES*IRQW-1:0] line_irq;
  logic [N_IRQ-1:0]        pic_vec;
  logic [N_IRQ-1:0]        apic_vec;

  assign req = ~pirq_n;

  pirq_route_regs #(
    .N_LINES(N_LINES), .IRQW(IRQW), .REGW(REGW), .AW(AW)
  ) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .line_en(line_en), .line_irq(line_irq), .err(route_err)
  );

  pirq_pic_map #(
    .N_LINES(N_LINES), .IRQW(IRQW), .N_IRQ(N_IRQ)
  ) u_pic (
    .req(req), .line_en(line_en), .line_irq(line_irq), .irq_vec(pic_vec)
  );

  pirq_apic_map #(
    .N_LINES(N_LINES), .N_IRQ(N_IRQ), .APIC_BASE(APIC_BASE)
  ) u_apic (
    .req(req), .irq_vec(apic_vec)
  );

  // single output stage: both modes switch cleanly at one edge
  always_ff @(posedge clk) begin
    if (rst) irq_out <= '0;
    else     irq_out <= apic_mode ? apic_vec : pic_vec;
  end
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int N_LINES   = 8,
  parameter int N_IRQ     = 24,
  parameter int IRQW      = 4,
  parameter int APIC_BASE = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               apic_mode,
  input logic [N_LINES-1:0] pirq_n,
  input logic               reg_we,
  input logic               wr_dis,
  input logic [IRQW-1:0]    wr_irq,
  input logic [N_IRQ-1:0]   irq_out,
  input logic               route_err
);
  import pirq_pkg::*;

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  p_apic_map_r7: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(apic_mode) |->
      irq_out[APIC_BASE +: N_LINES] == ~$past(pirq_n));

  p_pic_high_zero_r8: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(apic_mode) |-> irq_out[APIC_BASE +: N_LINES] == '0);

  p_apic_low_zero_r8: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(apic_mode) |-> irq_out[APIC_BASE-1:0] == '0);

  p_never_reserved_r2: assert property (@(posedge clk) disable iff (rst)
    (irq_out[15:0] & ~PIC_LEGAL) == '0);

  p_illegal_flags_r5: assert property (@(posedge clk) disable iff (rst)
    reg_we && !wr_dis && !irq_is_legal(wr_irq) |=> route_err);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    route_err |=> route_err);
endmodule

bind pirq_router pirq_router_chk #(
  .N_LINES(N_LINES), .N_IRQ(N_IRQ), .IRQW(IRQW), .APIC_BASE(APIC_BASE)
) u_chk (
  .clk(clk), .rst(rst), .apic_mode(apic_mode), .pirq_n(pirq_n),
  .reg_we(reg_we), .wr_dis(reg_wdata[REGW-1]), .wr_irq(reg_wdata[IRQW-1:0]),
  .irq_out(irq_out), .route_err(route_err)
);

// File: tb/pirq_router_tb.sv
module pirq_router_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        apic_mode = 1'b0;
  logic [7:0]  pirq_n = 8'hFF;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [23:0] irq_out;
  logic        route_err;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic done = 1'b0;
  logic [7:0] m_reg [8];
  logic       m_err;

  always #10 clk = ~clk;

  pirq_router u_dut (
    .clk(clk), .rst(rst), .apic_mode(apic_mode), .pirq_n(pirq_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out), .route_err(route_err)
  );

  function automatic logic legal(input int n);
    return n >= 3 && n <= 15 && n != 8 && n != 13;
  endfunction

  function automatic logic [23:0] model(input logic [7:0] pn, input logic md);
    logic [23:0] v = '0;
    for (int k = 0; k < 8; k++) begin
      if (!pn[k]) begin
        if (md) v[16+k] = 1'b1;
        else if (!m_reg[k][7]) v[m_reg[k][3:0]] = 1'b1;
      end
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    reg_addr  = 3'(a);
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    if (!d[7] && !legal(int'(d[3:0]))) begin
      m_reg[a] = d | 8'h80;
      m_err = 1'b1;
    end else m_reg[a] = d;
  endtask

  task automatic rd_check(input string req, input int a);
    reg_addr = 3'(a);
    @(negedge clk);
    check(req, 32'(reg_rdata), 32'(m_reg[a]));
  endtask

  task automatic drive_check(input string req, input logic [7:0] pn);
    pirq_n = pn;
    @(negedge clk);
    check(req, 32'(irq_out), 32'(model(pn, apic_mode)));
  endtask

  task automatic do_reset;
    rst = 1'b1;
    pirq_n = 8'hFF;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) m_reg[k] = 8'h80;
    m_err = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      finish_run();
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    check("R1 irq_out", 32'(irq_out), 0);
    check("R1 route_err", 32'(route_err), 0);
    for (int a = 0; a < 8; a++) rd_check("R1 reg reset", a);

    // R2/R5/R4: every line against every IRQ number
    for (int ln = 0; ln < 8; ln++) begin
      for (int n = 0; n < 16; n++) begin
        wr(ln, 8'(n));
        drive_check("R2 route sweep", ~(8'd1 << ln));
        check("R5 err flag", 32'(route_err), 32'(m_err));
        if (!legal(n)) rd_check("R5 forced disable", ln);
      end
      wr(ln, 8'h80 | 8'd5);
      drive_check("R4 disabled line", ~(8'd1 << ln));
    end
    drive_check("R2 idle", 8'hFF);

    // R6 sticky after legal writes
    wr(0, 8'h03);
    wr(1, 8'h8C);
    check("R6 sticky", 32'(route_err), 1);

    // R9 addressing and full-byte storage
    for (int a = 0; a < 8; a++) wr(a, 8'(8'h73 - a * 16 + 0));
    for (int a = 0; a < 8; a++) rd_check("R9 readback", a);

    // R3 sharing: all on IRQ 10, line 3 disabled
    for (int a = 0; a < 8; a++) wr(a, (a == 3) ? 8'h8A : 8'h0A);
    for (int p = 0; p < 256; p++) drive_check("R3 shared", 8'(p));

    // R2 mixed distinct routes
    wr(0, 8'h03); wr(1, 8'h04); wr(2, 8'h05); wr(3, 8'h06);
    wr(4, 8'h07); wr(5, 8'h09); wr(6, 8'h0B); wr(7, 8'h0E);
    for (int p = 0; p < 256; p++) drive_check("R2 mixed", 8'(p));

    // R7/R8 fixed routing ignores registers
    apic_mode = 1'b1;
    for (int p = 0; p < 256; p++) drive_check("R7 apic", 8'(p));

    // R10 mode switch at next edge
    pirq_n = 8'h5A;
    @(negedge clk);
    apic_mode = 1'b0;
    @(negedge clk);
    check("R10 to pic", 32'(irq_out), 32'(model(8'h5A, 1'b0)));
    apic_mode = 1'b1;
    @(negedge clk);
    check("R10 to apic", 32'(irq_out), 32'(model(8'h5A, 1'b1)));
    apic_mode = 1'b0;
    @(negedge clk);
    check("R8 pic high zero", 32'(irq_out[23:16]), 0);

    // R6 cleared only by reset; R1 again
    do_reset();
    @(negedge clk);
    check("R6 reset clears", 32'(route_err), 0);
    check("R1 irq after reset", 32'(irq_out), 0);
    rd_check("R1 reg after reset", 5);

    finish_run();
  end
endmodule